// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block derives a slower clock-rate signal from a gated input enable by counting enabled cycles of the single system clock. In single mode every output period lasts N1 enabled cycles. In dual mode the block alternates between two integer divisors. It produces M1 periods of N1 cycles, then M2 periods of N2 cycles, and repeats. The mean output rate is therefore fin*(M1+M2)/(N1*M1 + N2*M2). This mean can sit between two integer ratios, which allows, for example, a precise 32.768 kHz tick from a faster reference.

Each divisor has its own cycle counter and its own period counter. The counter of the active divisor decides when control passes to the other divisor. Configuration pins may change at any time. The block copies them into its working registers only at reset and at the end of a whole sequence, so an output period is never cut short. A status pin shows which divisor is active.

Top module: `frac_clk_div`

## Requirements
- R1: In single mode (cfg_dual = 0) each output period lasts N1 enabled cycles, where N1 = cfg_n1 + 1. The divider cycle counter never exceeds N1 - 1.
- R2: In dual mode (cfg_dual = 1), starting from reset, the output gives M1 periods of N1 enabled cycles and then M2 periods of N2 enabled cycles, and the pattern repeats. Here M1 = cfg_m1 + 1, N2 = cfg_n2 + 1 and M2 = cfg_m2 + 1.
- R3: When the active divisor field is 0 (divisor 1), clk_out equals en in the same cycle.
- R4: For a divisor N of 2 or more, each period begins low for N - floor(N/2) enabled cycles and is then high for floor(N/2) enabled cycles.
- R5: Configuration changes take effect only after the sequence in progress completes. In single mode a sequence is one N1 period. In dual mode it is the full M1+M2 pattern. Working configuration is never altered partway through a period.
- R6: phase_sel is 0 while the N1 divisor is active and 1 while the N2 divisor is active.
- R7: After a synchronous reset (rst high at a clock edge), phase_sel is 0, all counters are cleared, and clk_out is low whenever N1 is 2 or more.
- R8: A cycle with en low advances nothing: phase_sel and the counters keep their values. For a divisor of 2 or more, clk_out also keeps its value.
- R9: In single mode phase_sel stays 0, and the N2 and M2 fields have no effect on clk_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Input enable; each high cycle is one input tick |
| cfg_dual | input | 1 | 0 = single divisor, 1 = alternate two divisors |
| cfg_n1 | input | 12 | First divisor minus one |
| cfg_m1 | input | 12 | Period count for first divisor minus one |
| cfg_n2 | input | 12 | Second divisor minus one |
| cfg_m2 | input | 12 | Period count for second divisor minus one |
| clk_out | output | 1 | Divided output level |
| phase_sel | output | 1 | Active divisor: 0 first, 1 second |

## Verification
The assertions assume that rst is held high for at least one clock edge before any check is meaningful. They also assume that clk_out is a pure function of en only while a divisor of 1 is active, so the checks on the output level are limited to divisors of two or more. The bench drives en in bursts from tasks that change inputs just after a rising edge. It changes configuration pins only while en is low or in the middle of a known sequence, and its expected stream always starts from a freshly reset divider. Holds on en are inserted only where the active divisor is at least two, which keeps the output stable during the hold.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned DEF_DIV_W = 12;
  localparam int unsigned DEF_REP_W = 12;
  localparam int unsigned NUM_STAGES = 2;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;
endpackage

// File: rtl/frac_div_shadow.sv
module frac_div_shadow #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned REP_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             in_dual,
  input  logic [DIV_W-1:0] in_n1,
  input  logic [REP_W-1:0] in_m1,
  input  logic [DIV_W-1:0] in_n2,
  input  logic [REP_W-1:0] in_m2,
  output logic             act_dual,
  output logic [DIV_W-1:0] act_n1,
  output logic [REP_W-1:0] act_m1,
  output logic [DIV_W-1:0] act_n2,
  output logic [REP_W-1:0] act_m2
);
  // working copy is refreshed at reset and at each sequence boundary
  always_ff @(posedge clk) begin
    if (rst || load) begin
      act_dual <= in_dual;
      act_n1   <= in_n1;
      act_m1   <= in_m1;
      act_n2   <= in_n2;
      act_m2   <= in_m2;
    end
  end
endmodule

// File: rtl/frac_div_stage.sv
module frac_div_stage #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned REP_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             en_raw,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [REP_W-1:0] rep_m1,
  output logic [DIV_W-1:0] cnt,
  output logic             wrap,
  output logic             last,
  output logic             lvl
);
  localparam int unsigned CW = DIV_W + 1;

  logic [REP_W-1:0] rep;
  logic [CW-1:0]    full;
  logic [CW-1:0]    hi_len;
  logic [CW-1:0]    lo_len;

  assign wrap = run && (cnt == div_m1);
  assign last = wrap && (rep == rep_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      rep <= '0;
    end else if (run) begin
      if (cnt == div_m1) begin
        cnt <= '0;
        rep <= (rep == rep_m1) ? '0 : rep + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // low part first, then floor(N/2) high cycles
  always_comb begin
    full   = {1'b0, div_m1} + 1'b1;
    hi_len = full >> 1;
    lo_len = full - hi_len;
    if (div_m1 == '0) lvl = en_raw;
    else              lvl = ({1'b0, cnt} >= lo_len);
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int unsigned DIV_W = DEF_DIV_W,
  parameter int unsigned REP_W = DEF_REP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cfg_dual,
  input  logic [DIV_W-1:0] cfg_n1,
  input  logic [REP_W-1:0] cfg_m1,
  input  logic [DIV_W-1:0] cfg_n2,
  input  logic [REP_W-1:0] cfg_m2,
  output logic             clk_out,
  output logic             phase_sel
);
  logic             act_dual;
  logic [DIV_W-1:0] act_n1, act_n2;
  logic [REP_W-1:0] act_m1, act_m2;
  phase_e           phase_q;
  logic             seq_end;

  logic [DIV_W-1:0] div_sel [NUM_STAGES];
  logic [REP_W-1:0] rep_sel [NUM_STAGES];
  logic [DIV_W-1:0] cnt_w   [NUM_STAGES];
  logic [NUM_STAGES-1:0] run_w, wrap_w, last_w, lvl_w;
  logic [DIV_W-1:0] cnt0, cnt1;

  frac_div_shadow #(.DIV_W(DIV_W), .REP_W(REP_W)) shadow_i (
    .clk(clk), .rst(rst), .load(seq_end),
    .in_dual(cfg_dual), .in_n1(cfg_n1), .in_m1(cfg_m1),
    .in_n2(cfg_n2), .in_m2(cfg_m2),
    .act_dual(act_dual), .act_n1(act_n1), .act_m1(act_m1),
    .act_n2(act_n2), .act_m2(act_m2)
  );

  // single mode pins the first repeat count to one period
  assign div_sel[0] = act_n1;
  assign rep_sel[0] = act_dual ? act_m1 : '0;
  assign div_sel[1] = act_n2;
  assign rep_sel[1] = act_m2;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    assign run_w[g] = en && (phase_q == phase_e'(g));
    frac_div_stage #(.DIV_W(DIV_W), .REP_W(REP_W)) stage_i (
      .clk(clk), .rst(rst), .run(run_w[g]), .en_raw(en),
      .div_m1(div_sel[g]), .rep_m1(rep_sel[g]),
      .cnt(cnt_w[g]), .wrap(wrap_w[g]), .last(last_w[g]), .lvl(lvl_w[g])
    );
  end

  assign cnt0 = cnt_w[0];
  assign cnt1 = cnt_w[1];

  assign seq_end = act_dual ? ((phase_q == PH_SECOND) && last_w[1]) : wrap_w[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FIRST;
    end else if (!act_dual) begin
      phase_q <= PH_FIRST;
    end else if ((phase_q == PH_FIRST) && last_w[0]) begin
      phase_q <= PH_SECOND;
    end else if ((phase_q == PH_SECOND) && last_w[1]) begin
      phase_q <= PH_FIRST;
    end
  end

  assign phase_sel = (phase_q == PH_SECOND);
  assign clk_out   = phase_sel ? lvl_w[1] : lvl_w[0];
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned REP_W = 12,
  localparam int unsigned AW = 1 + 2 * DIV_W + 2 * REP_W
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             clk_out,
  input logic             phase_sel,
  input logic [DIV_W-1:0] cnt0,
  input logic [DIV_W-1:0] cnt1,
  input logic             act_dual,
  input logic [DIV_W-1:0] act_n1,
  input logic [AW-1:0]    act_word
);
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!phase_sel && cnt0 == '0 && cnt1 == '0));

  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (!phase_sel) |-> (cnt0 <= act_n1));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !rst) |=> ($stable(phase_sel) && $stable(cnt0) && $stable(cnt1)));

  a_r9_single_stays_first: assert property (@(posedge clk) disable iff (rst)
    (!act_dual && !phase_sel) |=> !phase_sel);

  a_r5_cfg_fixed_mid_period: assert property (@(posedge clk) disable iff (rst)
    (!rst && !phase_sel && cnt0 != '0) |=> $stable(act_word));

  a_r4_period_starts_low: assert property (@(posedge clk) disable iff (rst)
    (!phase_sel && cnt0 == '0 && act_n1 != '0) |-> !clk_out);
endmodule

bind frac_clk_div frac_clk_div_chk #(.DIV_W(DIV_W), .REP_W(REP_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .clk_out(clk_out), .phase_sel(phase_sel),
  .cnt0(cnt0), .cnt1(cnt1), .act_dual(act_dual), .act_n1(act_n1),
  .act_word({act_dual, act_n1, act_m1, act_n2, act_m2})
);

// File: tb/frac_clk_div_tb_top.sv
module frac_clk_div_tb_top;
  localparam int unsigned DW = 12;
  localparam int unsigned RW = 12;

  typedef struct {
    logic  lvl;
    logic  ph;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          cfg_dual = 1'b0;
  logic [DW-1:0] cfg_n1 = '0;
  logic [RW-1:0] cfg_m1 = '0;
  logic [DW-1:0] cfg_n2 = '0;
  logic [RW-1:0] cfg_m2 = '0;
  logic          clk_out;
  logic          phase_sel;

  int   n_run  = 0;
  int   n_fail = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  frac_clk_div #(.DIV_W(DW), .REP_W(RW)) dut_i (
    .clk(clk), .rst(rst), .en(en), .cfg_dual(cfg_dual),
    .cfg_n1(cfg_n1), .cfg_m1(cfg_m1), .cfg_n2(cfg_n2), .cfg_m2(cfg_m2),
    .clk_out(clk_out), .phase_sel(phase_sel)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: one expected item per enabled cycle
  always @(negedge clk) begin
    if (!rst && en && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(clk_out === e.lvl, {e.req, " level"}, int'(clk_out), int'(e.lvl));
      chk(phase_sel === e.ph, {e.req, " phase"}, int'(phase_sel), int'(e.ph));
    end
  end

  task automatic set_cfg(input logic d, input int n1, input int m1, input int n2, input int m2);
    cfg_dual = d;
    cfg_n1 = DW'(n1 - 1);
    cfg_m1 = RW'(m1 - 1);
    cfg_n2 = DW'(n2 - 1);
    cfg_m2 = RW'(m2 - 1);
  endtask

  task automatic push_periods(input int n, input int m, input logic ph, input string req);
    for (int p = 0; p < m; p++)
      for (int c = 0; c < n; c++) begin
        exp_t e;
        e.lvl = (n == 1) ? 1'b1 : (c >= n - n / 2);
        e.ph  = ph;
        e.req = req;
        q.push_back(e);
      end
  endtask

  task automatic push_seq(input logic d, input int n1, input int m1, input int n2, input int m2,
                          input string req);
    if (d) begin
      push_periods(n1, m1, 1'b0, req);
      push_periods(n2, m2, 1'b1, req);
    end else begin
      push_periods(n1, 1, 1'b0, req);
    end
  endtask

  task automatic do_reset();
    en  = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // driver: runs en until the queue drains; optional hold when gap_left items remain
  task automatic run_items(input int gap_left);
    en = 1'b1;
    while (q.size() > 0) begin
      @(posedge clk);
      #1;
      if (gap_left > 0 && q.size() == gap_left) begin
        logic ho, hp;
        en = 1'b0;
        @(negedge clk);
        ho = clk_out;
        hp = phase_sel;
        repeat (5) begin
          @(negedge clk);
          chk(clk_out === ho, "R8 hold level", int'(clk_out), int'(ho));
          chk(phase_sel === hp, "R8 hold phase", int'(phase_sel), int'(hp));
        end
        @(posedge clk);
        #1 en = 1'b1;
        gap_left = 0;
      end
    end
    en = 1'b0;
  endtask

  initial begin
    // R7: reset state, dual A = N1 3, M1 2, N2 4, M2 1
    set_cfg(1'b1, 3, 2, 4, 1);
    do_reset();
    @(negedge clk);
    chk(phase_sel === 1'b0, "R7 phase after reset", int'(phase_sel), 0);
    chk(clk_out === 1'b0, "R7 output after reset", int'(clk_out), 0);

    // R5 and R2: new config (N1 5, M1 1, N2 2, M2 3) waits for A to finish
    @(posedge clk);
    #1 set_cfg(1'b1, 5, 1, 2, 3);
    push_seq(1'b1, 3, 2, 4, 1, "R5");
    push_seq(1'b1, 5, 1, 2, 3, "R2");
    push_seq(1'b1, 5, 1, 2, 3, "R6");
    run_items(0);

    // R1 and R9: single N1 4, junk in second fields
    set_cfg(1'b0, 4, 7, 3, 2);
    do_reset();
    push_seq(1'b0, 4, 1, 1, 1, "R1");
    push_seq(1'b0, 4, 1, 1, 1, "R9");
    push_seq(1'b0, 4, 1, 1, 1, "R9");
    run_items(0);

    // R4 and R8: odd divisor 5, hold midway
    set_cfg(1'b0, 5, 1, 9, 9);
    do_reset();
    push_seq(1'b0, 5, 1, 1, 1, "R4");
    push_seq(1'b0, 5, 1, 1, 1, "R4");
    push_seq(1'b0, 5, 1, 1, 1, "R8");
    run_items(7);

    // R3: divisor 1 passes en through
    set_cfg(1'b0, 1, 1, 1, 1);
    do_reset();
    push_seq(1'b0, 1, 1, 1, 1, "R3");
    push_seq(1'b0, 1, 1, 1, 1, "R3");
    push_seq(1'b0, 1, 1, 1, 1, "R3");
    run_items(0);
    @(negedge clk);
    chk(clk_out === 1'b0, "R3 output follows low en", int'(clk_out), 0);

    // R2 and R3: dual with divisor 1 first, N2 2 second
    set_cfg(1'b1, 1, 2, 2, 2);
    do_reset();
    push_seq(1'b1, 1, 2, 2, 2, "R2");
    push_seq(1'b1, 1, 2, 2, 2, "R6");
    run_items(0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule